// File: doc/BRIEF.md
# Cached FFT Address Sequencer

This block turns the loop counters of a radix-2 cached FFT into the addresses that the memories around the butterfly unit need. The transform length can be anything from 64 to 2048 points. The controller presents, once per butterfly, the transform size, the super-stage, the pass within the group, a group counter and a butterfly counter. One clock later the block returns four data addresses and one twiddle address:

- the main-memory address of each of the two operands;
- the position of each operand inside the cache;
- the twiddle-table index.

The transform runs in two super stages. During a super stage the digits that the group counter drives stay in fixed positions, so every group fits in the cache. The split gives the first super stage the ceiling of half the address digits and the second super stage the remainder. The low half of the main-memory address is cached first, then the high half.

A single twiddle table sized for 2048 points serves every length. The twiddle index is always formed in that table's numbering, and smaller transforms read every 2^(11-log2 N)-th entry. For the inverse transform the twiddle index is unchanged and a conjugate flag goes to the arithmetic unit.

Top module: `fft_cache_agu`

## Requirements
- R1: Size code c in 0..5 selects an N = 64·2^c point transform (n = 6 + c address digits). Codes 6 and 7 are rejected: no output strobe follows, and the addresses hold.
- R2: Cache width is d0 = ceil(n/2) digits in super stage 0 (super_stage = 0) and d1 = n - d0 in super stage 1. The butterfly counter uses its low (cache width - 1) bits and the group counter uses its low (n - cache width) bits. Higher counter bits have no effect.
- R3: The operand A cache address is the masked butterfly counter with a 0 inserted at bit position p (p = pass index), bits at and above p moving up one place. Operand B is the same with a 1 inserted.
- R4: In super stage 0 the main-memory address is {group, cache address}, with the cache address in the low d0 digits. In super stage 1 it is {cache address, group}, with the group in the low d0 digits.
- R5: The two operand memory addresses differ in exactly one bit: bit p in super stage 0, and bit d0 + p in super stage 1.
- R6: Let t be the global stage (t = p in super stage 0, t = d0 + p in super stage 1). The 10-bit twiddle index is the low t bits of operand A's memory address shifted left by 10 - t. It is zero on pass 0 of super stage 0 for every size.
- R7: An accepted request is reflected on the outputs after exactly one rising clock edge, with out_valid high for that one cycle.
- R8: While req_valid is low, out_valid is low on the next cycle and all address outputs keep their previous values.
- R9: A request whose pass index is not below the cache width of its super stage is rejected: out_valid stays low and the addresses hold.
- R10: conj equals the inverse input of an accepted request. The twiddle index does not depend on inverse, and conj is low whenever out_valid is low.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A butterfly request is presented |
| size_code | input | 3 | Transform length select, N = 64·2^code |
| inverse | input | 1 | Request belongs to an inverse transform |
| super_stage | input | 1 | Super-stage index, 0 or 1 |
| pass_idx | input | 3 | Pass index within the group |
| group_cnt | input | 6 | Group counter |
| bfly_cnt | input | 5 | Butterfly counter within the pass |
| out_valid | output | 1 | Addresses below belong to an accepted request |
| mem_addr_a | output | 11 | Main-memory address of operand A |
| mem_addr_b | output | 11 | Main-memory address of operand B |
| cache_addr_a | output | 6 | Cache address of operand A |
| cache_addr_b | output | 6 | Cache address of operand B |
| rom_addr | output | 10 | Twiddle index in the 2048-point table |
| conj | output | 1 | Conjugate the twiddle factor |

## Verification
The block holds only its output register, so a wrong digit placement or a wrong split appears in the very next cycle as a mismatching address. The reference model rebuilds each address with integer arithmetic, and every cycle is compared. Odd digit counts (128, 512, 2048 points) are where a floor/ceiling mix-up between the super stages shows. The top pass of each super stage and the pass just beyond it expose off-by-one errors in the reject rule. Idle cycles and rejected requests check that a stale or garbage address never overwrites the held outputs.

// File: rtl/fft_cache_agu_pkg.sv
package fft_cache_agu_pkg;

   // Digit-count limit of the geometry fields below.
   localparam int GEOM_FIELD_MAX = 31;

   // Digit geometry of one transform length.
   typedef struct packed {
      logic [4:0] log_n;     // address digits of the transform
      logic [4:0] first_w;   // cache digits of super stage 0
      logic [4:0] second_w;  // cache digits of super stage 1
   } agu_geom_t;

endpackage

// File: rtl/agu_geometry.sv
module agu_geometry
   import fft_cache_agu_pkg::*;
#(
   parameter int LOG_MIN    = 6,
   parameter int LOG_MAX    = 11,
   parameter int CODE_W     = 3,
   parameter int FIRST_CEIL = 1
) (
   input  logic [CODE_W-1:0] size_code,
   output agu_geom_t         geom,
   output logic              size_ok
);
   localparam int SPAN = LOG_MAX - LOG_MIN;

   logic [4:0] log_n;
   logic [4:0] half_lo;
   logic [4:0] half_hi;
   logic [4:0] first_sel;
   logic [4:0] second_sel;

   always_comb begin
      log_n   = 5'(LOG_MIN) + 5'(size_code);
      half_lo = log_n >> 1;
      half_hi = log_n - half_lo;
      size_ok = (int'(size_code) <= SPAN);
   end

   // Variant: which super stage takes the larger half of an odd digit count.
   if (FIRST_CEIL != 0) begin : g_ceil_first
      assign first_sel  = half_hi;
      assign second_sel = half_lo;
   end else begin : g_floor_first
      assign first_sel  = half_lo;
      assign second_sel = half_hi;
   end

   always_comb begin
      geom.log_n    = log_n;
      geom.first_w  = first_sel;
      geom.second_w = second_sel;
   end

endmodule

// File: rtl/agu_operand_lane.sv
module agu_operand_lane
   import fft_cache_agu_pkg::*;
#(
   parameter int LOG_MAX = 11,
   parameter int OPERAND = 0,
   localparam int CW = (LOG_MAX + 1) / 2,
   localparam int BW = CW - 1,
   localparam int PW = $clog2(CW)
) (
   input  agu_geom_t         geom,
   input  logic              super_stage,
   input  logic [PW-1:0]     pass_idx,
   input  logic [CW-1:0]     group_cnt,
   input  logic [BW-1:0]     bfly_cnt,
   output logic [CW-1:0]     cache_addr,
   output logic [LOG_MAX-1:0] mem_addr
);
   function automatic logic [BW-1:0] ones_b(input logic [4:0] amt);
      ones_b = ~({BW{1'b1}} << amt);
   endfunction

   function automatic logic [CW-1:0] ones_c(input logic [4:0] amt);
      ones_c = ~({CW{1'b1}} << amt);
   endfunction

   logic [4:0]    cbits;
   logic [4:0]    gbits;
   logic [4:0]    p5;
   logic [BW-1:0] k_used;
   logic [CW-1:0] g_used;
   logic [CW-1:0] k_wide;
   logic [CW-1:0] upper;
   logic [CW-1:0] lower;
   logic [CW-1:0] pick;

   always_comb begin
      cbits  = super_stage ? geom.second_w : geom.first_w;
      gbits  = geom.log_n - cbits;
      p5     = 5'(pass_idx);
      // R2: counter bits beyond the active geometry are masked off
      k_used = bfly_cnt & ones_b(cbits - 5'd1);
      g_used = group_cnt & ones_c(gbits);
      k_wide = {1'b0, k_used};
      // R3: open a hole at bit p and fill it with this lane's operand bit
      upper  = (k_wide >> p5) << (p5 + 5'd1);
      lower  = k_wide & ones_c(p5);
      pick   = CW'(OPERAND) << p5;
      cache_addr = upper | lower | pick;
      // R4: cached field is low in super stage 0, high in super stage 1
      if (!super_stage) begin
         mem_addr = (LOG_MAX'(g_used) << cbits) | LOG_MAX'(cache_addr);
      end else begin
         mem_addr = (LOG_MAX'(cache_addr) << geom.first_w) | LOG_MAX'(g_used);
      end
   end

endmodule

// File: rtl/agu_twiddle_index.sv
module agu_twiddle_index #(
   parameter int LOG_MAX = 11,
   localparam int CW = (LOG_MAX + 1) / 2,
   localparam int PW = $clog2(CW),
   localparam int RW = LOG_MAX - 1
) (
   input  logic [4:0]    first_w,
   input  logic          super_stage,
   input  logic [PW-1:0] pass_idx,
   input  logic [RW-1:0] mem_low,
   output logic [RW-1:0] rom_addr
);
   function automatic logic [RW-1:0] ones_r(input logic [4:0] amt);
      ones_r = ~({RW{1'b1}} << amt);
   endfunction

   logic [4:0] stage;

   always_comb begin
      stage    = super_stage ? (first_w + 5'(pass_idx)) : 5'(pass_idx);
      // R6: index in full-size table numbering, independent of the size
      rom_addr = (mem_low & ones_r(stage)) << (5'(RW) - stage);
   end

endmodule

// File: rtl/fft_cache_agu.sv
module fft_cache_agu
   import fft_cache_agu_pkg::*;
#(
   parameter int LOG_MIN    = 6,
   parameter int LOG_MAX    = 11,
   parameter int CODE_W     = 3,
   parameter int FIRST_CEIL = 1,
   localparam int CW = (LOG_MAX + 1) / 2,
   localparam int BW = CW - 1,
   localparam int PW = $clog2(CW),
   localparam int RW = LOG_MAX - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [CODE_W-1:0]  size_code,
   input  logic               inverse,
   input  logic               super_stage,
   input  logic [PW-1:0]      pass_idx,
   input  logic [CW-1:0]      group_cnt,
   input  logic [BW-1:0]      bfly_cnt,
   output logic               out_valid,
   output logic [LOG_MAX-1:0] mem_addr_a,
   output logic [LOG_MAX-1:0] mem_addr_b,
   output logic [CW-1:0]      cache_addr_a,
   output logic [CW-1:0]      cache_addr_b,
   output logic [RW-1:0]      rom_addr,
   output logic               conj
);
   // Elaboration-time configuration checks
   if (LOG_MIN < 4) begin : g_bad_min
      $error("fft_cache_agu: LOG_MIN must be at least 4");
   end
   if (LOG_MAX <= LOG_MIN || LOG_MAX > GEOM_FIELD_MAX) begin : g_bad_max
      $error("fft_cache_agu: LOG_MAX out of range");
   end
   if ((LOG_MAX - LOG_MIN) >= (1 << CODE_W)) begin : g_bad_code
      $error("fft_cache_agu: CODE_W too narrow for the size range");
   end
   if (FIRST_CEIL != 0 && FIRST_CEIL != 1) begin : g_bad_split
      $error("fft_cache_agu: FIRST_CEIL must be 0 or 1");
   end

   agu_geom_t  geom;
   logic       size_ok;
   logic [4:0] cbits_sel;
   logic       req_ok;

   agu_geometry #(
      .LOG_MIN   (LOG_MIN),
      .LOG_MAX   (LOG_MAX),
      .CODE_W    (CODE_W),
      .FIRST_CEIL(FIRST_CEIL)
   ) i_geometry (
      .size_code(size_code),
      .geom     (geom),
      .size_ok  (size_ok)
   );

   always_comb begin
      cbits_sel = super_stage ? geom.second_w : geom.first_w;
      // R1 / R9: reject unknown sizes and passes beyond the cache width
      req_ok    = size_ok && (5'(pass_idx) < cbits_sel);
   end

   logic [CW-1:0]      lane_cache [2];
   logic [LOG_MAX-1:0] lane_mem   [2];

   for (genvar op = 0; op < 2; op++) begin : g_lane
      agu_operand_lane #(
         .LOG_MAX(LOG_MAX),
         .OPERAND(op)
      ) i_lane (
         .geom       (geom),
         .super_stage(super_stage),
         .pass_idx   (pass_idx),
         .group_cnt  (group_cnt),
         .bfly_cnt   (bfly_cnt),
         .cache_addr (lane_cache[op]),
         .mem_addr   (lane_mem[op])
      );
   end

   logic [RW-1:0] rom_next;

   agu_twiddle_index #(
      .LOG_MAX(LOG_MAX)
   ) i_twiddle (
      .first_w    (geom.first_w),
      .super_stage(super_stage),
      .pass_idx   (pass_idx),
      .mem_low    (lane_mem[0][RW-1:0]),
      .rom_addr   (rom_next)
   );

   logic accept;
   assign accept = req_valid && req_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         conj         <= 1'b0;
         mem_addr_a   <= '0;
         mem_addr_b   <= '0;
         cache_addr_a <= '0;
         cache_addr_b <= '0;
         rom_addr     <= '0;
      end else begin
         out_valid <= accept;
         conj      <= accept && inverse;
         if (accept) begin
            mem_addr_a   <= lane_mem[0];
            mem_addr_b   <= lane_mem[1];
            cache_addr_a <= lane_cache[0];
            cache_addr_b <= lane_cache[1];
            rom_addr     <= rom_next;
         end
      end
   end

   // R7: accepted request strobes out one cycle later
   a_r7_one_cycle_latency : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ok) |=> out_valid);

   // R8: idle input leaves outputs idle and held
   a_r8_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && $stable(mem_addr_a) && $stable(rom_addr)));

   // R9: rejected request produces no strobe
   a_r9_reject_silent : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ok) |=> (!out_valid && $stable(mem_addr_b)));

   // R5: operands differ in a single memory and cache bit
   a_r5_pair_one_bit : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(mem_addr_a ^ mem_addr_b) == 1
                     && $countones(cache_addr_a ^ cache_addr_b) == 1));

   // R6: first pass of the first super stage uses twiddle index zero
   a_r6_first_pass_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !super_stage && pass_idx == '0) |=> (rom_addr == '0));

   // R10: no conjugate flag without a valid strobe
   a_r10_conj_gated : assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !conj);

endmodule

// File: tb/test_fft_cache_agu.sv
module test_fft_cache_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  size_code = '0;
   logic        inverse = 1'b0;
   logic        super_stage = 1'b0;
   logic [2:0]  pass_idx = '0;
   logic [5:0]  group_cnt = '0;
   logic [4:0]  bfly_cnt = '0;
   logic        out_valid;
   logic [10:0] mem_addr_a, mem_addr_b;
   logic [5:0]  cache_addr_a, cache_addr_b;
   logic [9:0]  rom_addr;
   logic        conj;

   int total = 0;
   int fails = 0;

   // expected output state
   int e_valid = 0, e_conj = 0, e_ma = 0, e_mb = 0, e_ca = 0, e_cb = 0, e_rom = 0;

   always #5 clk = ~clk;

   fft_cache_agu i_fft_cache_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .size_code(size_code),
      .inverse(inverse), .super_stage(super_stage), .pass_idx(pass_idx),
      .group_cnt(group_cnt), .bfly_cnt(bfly_cnt), .out_valid(out_valid),
      .mem_addr_a(mem_addr_a), .mem_addr_b(mem_addr_b),
      .cache_addr_a(cache_addr_a), .cache_addr_b(cache_addr_b),
      .rom_addr(rom_addr), .conj(conj)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // Present one request, compute the expected result, compare after one edge.
   task automatic step(input int code, input int ss, input int p,
                       input int grp, input int bf, input int vld, input int inv);
      int n, d0, d1, c, k, g, ca, ma, mb, t;
      string vtag;
      req_valid   = vld[0];
      size_code   = code[2:0];
      super_stage = ss[0];
      pass_idx    = p[2:0];
      group_cnt   = grp[5:0];
      bfly_cnt    = bf[4:0];
      inverse     = inv[0];
      n  = 6 + code;
      d0 = (n + 1) / 2;
      d1 = n - d0;
      c  = (ss == 0) ? d0 : d1;
      if (vld == 0)      vtag = "R8";
      else if (code > 5) vtag = "R1";
      else if (p >= c)   vtag = "R9";
      else               vtag = "R7";
      if (vld != 0 && code <= 5 && p < c) begin
         k  = bf % (1 << (c - 1));          // R2 masking
         g  = grp % (1 << (n - c));
         ca = (k / (1 << p)) * (1 << (p + 1)) + k % (1 << p);
         if (ss == 0) begin
            ma = g * (1 << c) + ca;
            mb = ma + (1 << p);
            t  = p;
         end else begin
            ma = ca * (1 << d0) + g;
            mb = ma + (1 << (d0 + p));
            t  = d0 + p;
         end
         e_valid = 1;
         e_conj  = inv;
         e_ca    = ca;
         e_cb    = ca + (1 << p);
         e_ma    = ma;
         e_mb    = mb;
         e_rom   = (ma % (1 << t)) * (1 << (10 - t));
      end else begin
         e_valid = 0;
         e_conj  = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(vtag, int'(out_valid), e_valid);
      chk("R3", int'(cache_addr_a), e_ca);
      chk("R3", int'(cache_addr_b), e_cb);
      chk("R4", int'(mem_addr_a), e_ma);
      chk("R5", int'(mem_addr_b), e_mb);
      chk("R6", int'(rom_addr), e_rom);
      chk("R10", int'(conj), e_conj);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      summary();
   end

   initial begin
      // R11: reset state
      repeat (2) @(negedge clk);
      chk("R11", int'(out_valid), 0);
      chk("R11", int'(mem_addr_a), 0);
      chk("R11", int'(mem_addr_b), 0);
      chk("R11", int'(rom_addr), 0);
      chk("R11", int'(conj), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed 64-point case: super stage 1, pass 0, upper counter bits set (R2)
      step(0, 1, 0, 6'b111101, 5'b11010, 1, 0);

      // Sweep every size code, super stage and pass, with idle cycles
      for (int code = 0; code < 8; code++) begin
         for (int ss = 0; ss < 2; ss++) begin
            for (int p = 0; p < 7; p++) begin
               for (int rep = 0; rep < 6; rep++) begin
                  step(code, ss, p, int'($urandom % 64), int'($urandom % 32),
                       (rep == 2) ? 0 : 1, int'($urandom % 2));
               end
            end
         end
      end

      // Extremes of the counters at 2048 points
      step(5, 0, 5, 63, 31, 1, 1);
      step(5, 1, 4, 63, 31, 1, 0);
      step(5, 1, 5, 63, 31, 1, 0);
      summary();
   end

endmodule